// File: doc/BRIEF.md
# Serial Flash Block-Erase Sequencer

This block runs the whole erase of one 64 KiB block on an external serial NOR flash. It acts as the bus master on a single-bit SPI link in mode 0. A request carries a 24-bit block address and a poll limit. The sequencer then runs a fixed series of frames with no further help:

1. It enables writes.
2. It reads the status register once, to confirm that the write-enable latch took.
3. It sends the erase frame.
4. It polls the status register until the busy flag drops.

The outcome is reported with a one-cycle `done` or `err` pulse. When `err` pulses, a two-bit code gives the reason.

The serial clock runs at half the system clock. Each frame pulses the serial clock exactly as many times as the frame has bits. Chip-select rises in the cycle right after the last high phase, so the flash sees the frame end exactly on a byte boundary. Between frames, chip-select stays high for a minimum number of system cycles, set by a parameter.

Top module: `erase_sequencer`

## Requirements
- R1: `req_ready` is 1 only while the sequencer is idle. A request is taken when `req_valid` and `req_ready` are both 1, and `req_ready` is 0 in the cycle after it is taken, until the result pulse.
- R2: The first frame of every request is 8 clocks long and carries opcode 06h, most significant bit first.
- R3: The second frame is a 16-clock status read: opcode 05h, then 8 status bits read in MSB first. Status bit 1 is the write-enable latch. If it reads 0, the sequencer pulses `err` with `err_code` = 1 and sends no erase frame.
- R4: The erase frame is one chip-select assertion of exactly 32 clocks: opcode D8h, then `req_addr` bits 23 down to 0. Chip-select rises in the cycle right after the 32nd high phase.
- R5: After the erase, the sequencer repeats 16-clock status reads until status bit 0 (busy) reads 0. It then pulses `done`.
- R6: If the status read that shows busy = 0 also shows the write-enable latch = 1, the sequencer pulses `err` with `err_code` = 2 instead of `done`.
- R7: The sequencer counts status reads after the erase that show busy = 1. When that count reaches `req_poll_limit`, it pulses `err` with `err_code` = 3 and returns to idle. A limit of 0 acts as 1.
- R8: Between any two frames, chip-select stays high for at least `MIN_CS_HIGH` system cycles.
- R9: The serial clock is low whenever chip-select is high. MOSI holds steady while the serial clock is high. Each bit is one low phase and one high phase, each one system cycle long.
- R10: `done` and `err` are each one cycle wide, and they never assert together.
- R11: After reset: `spi_cs_n` = 1, `spi_sclk` = 0, `req_ready` = 1, and `done` = `err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Erase request valid |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | 24 | Block address, sent MSB first |
| req_poll_limit | input | 16 | Maximum number of busy status reads |
| done | output | 1 | One-cycle pulse: erase finished cleanly |
| err | output | 1 | One-cycle pulse: sequence failed |
| err_code | output | 2 | Failure reason, valid with `err`: 1 latch not set, 2 latch stuck, 3 timeout |
| spi_cs_n | output | 1 | Flash chip-select, active low |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions take three things for granted:
- The flash updates MISO only after a falling serial-clock edge.
- `req_valid` is driven cleanly, away from the sampling clock edge.
- `req_poll_limit` and `req_addr` hold steady during the cycle of the request.

The bench meets these conditions with a behavioural flash model. The model shifts status out on falling serial-clock edges and counts its own busy reads. All request fields are driven on falling system-clock edges, and `req_valid` is held for a single accepted cycle. The model's settings cover five cases: the latch taking or not, the latch clearing or not, and a busy time shorter than, equal to or longer than the poll limit.

// File: rtl/fe_pkg.sv
// Shared definitions for the flash block-erase sequencer: command opcodes,
// status bit positions, controller states and error codes.
package fe_pkg;

    localparam logic [7:0] OP_WRITE_EN  = 8'h06;
    localparam logic [7:0] OP_READ_STAT = 8'h05;
    localparam logic [7:0] OP_ERASE_64K = 8'hD8;

    localparam int STAT_BUSY = 0;
    localparam int STAT_WEL  = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WREN,
        ST_CHKWEL,
        ST_ERASE,
        ST_POLL
    } seq_state_t;

    typedef enum logic [1:0] {
        ERR_NONE        = 2'd0,
        ERR_WEL_MISSING = 2'd1,
        ERR_WEL_STUCK   = 2'd2,
        ERR_TIMEOUT     = 2'd3
    } err_code_t;

endpackage

// File: rtl/fe_spi_frame.sv
// Mode-0 SPI frame engine. It shifts out the top NBITS of a left-justified
// word, MSB first, within a single chip-select assertion. The serial clock
// runs at half the system clock (one low and one high system cycle per bit).
// It keeps the last two MISO samples, taken at the end of each high phase.
// Chip-select rises in the cycle right after the last high phase.
// Assumes: start is only raised while busy is low; nbits >= 1.
module fe_spi_frame #(
    parameter int FRAME_W = 32,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx,
    input  logic [CNT_W-1:0]   nbits,
    output logic               busy,
    output logic               done,
    output logic [1:0]         rx,
    output logic               cs_n,
    output logic               sclk,
    output logic               mosi,
    input  logic               miso
);

    logic               active;
    logic               phase_hi;
    logic [CNT_W-1:0]   bits_left;
    logic [FRAME_W-1:0] shreg;

    // Bit engine: frame start, low/high phase toggling, shift and sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            phase_hi  <= 1'b0;
            bits_left <= '0;
            shreg     <= '0;
            rx        <= '0;
            cs_n      <= 1'b1;
            sclk      <= 1'b0;
            mosi      <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active    <= 1'b1;
                    cs_n      <= 1'b0;
                    phase_hi  <= 1'b0;
                    bits_left <= nbits - 1'b1;
                    mosi      <= tx[FRAME_W-1];
                    shreg     <= tx << 1;
                end
            end else if (!phase_hi) begin
                sclk     <= 1'b1;
                phase_hi <= 1'b1;
            end else begin
                sclk     <= 1'b0;
                phase_hi <= 1'b0;
                rx       <= {rx[0], miso};
                if (bits_left == '0) begin
                    active <= 1'b0;
                    cs_n   <= 1'b1;
                    mosi   <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    bits_left <= bits_left - 1'b1;
                    mosi      <= shreg[FRAME_W-1];
                    shreg     <= shreg << 1;
                end
            end
        end
    end

    // Busy flag for the controller.
    always_comb busy = active;

endmodule

// File: rtl/fe_gap_timer.sv
// Chip-select idle timer. It is reloaded when a frame ends, and it reports
// idle once enough cycles have passed for chip-select to have stayed high for
// MIN_CS_HIGH cycles. The count already includes the done cycle and the
// launch cycle that every frame boundary has.
// Assumes: load is a single-cycle pulse at the end of each frame.
module fe_gap_timer #(
    parameter int MIN_CS_HIGH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic idle
);

    localparam int LOAD_VAL = (MIN_CS_HIGH > 2) ? MIN_CS_HIGH - 2 : 0;
    localparam int GW       = $clog2(LOAD_VAL + 2);

    logic [GW-1:0] remain;

    // Reload on frame end, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= GW'(LOAD_VAL);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // Idle once the countdown is finished.
    always_comb idle = (remain == '0);

endmodule

// File: rtl/fe_seq_ctrl.sv
// Erase sequence controller. It accepts a request, then issues in turn:
// write-enable, a status check of the latch, the erase frame, and status
// polls until busy clears, a failure is seen or the poll limit runs out.
// Each frame is launched once the gap timer reports chip-select idle.
// Assumes: frame_rx holds status bits [1:0] when frame_done pulses after a
// 16-bit status read.
module fe_seq_ctrl
    import fe_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int POLL_W  = 16,
    parameter int FRAME_W = 8 + ADDR_W,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [POLL_W-1:0]  req_poll_limit,
    input  logic               gap_idle,
    input  logic               frame_busy,
    input  logic               frame_done,
    input  logic [1:0]         frame_rx,
    output logic               frame_start,
    output logic [FRAME_W-1:0] frame_tx,
    output logic [CNT_W-1:0]   frame_nbits,
    output logic               done,
    output logic               err,
    output err_code_t          err_code
);

    localparam logic [CNT_W-1:0] NB_CMD   = CNT_W'(8);
    localparam logic [CNT_W-1:0] NB_READ  = CNT_W'(16);
    localparam logic [CNT_W-1:0] NB_ERASE = CNT_W'(FRAME_W);

    seq_state_t        state;
    logic              issued;
    logic [ADDR_W-1:0] addr_q;
    logic [POLL_W-1:0] limit_q;
    logic [POLL_W-1:0] poll_cnt;
    logic [POLL_W:0]   poll_next;

    // Frame contents for the current step and the launch condition.
    always_comb begin
        frame_tx    = {OP_WRITE_EN, {ADDR_W{1'b0}}};
        frame_nbits = NB_CMD;
        unique case (state)
            ST_CHKWEL, ST_POLL: begin
                frame_tx    = {OP_READ_STAT, {ADDR_W{1'b0}}};
                frame_nbits = NB_READ;
            end
            ST_ERASE: begin
                frame_tx    = {OP_ERASE_64K, addr_q};
                frame_nbits = NB_ERASE;
            end
            default: ;
        endcase
        frame_start = (state != ST_IDLE) && !issued && gap_idle && !frame_busy;
        req_ready   = (state == ST_IDLE);
        poll_next   = {1'b0, poll_cnt} + 1'b1;
    end

    // Step sequencing, result pulses and poll counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            issued   <= 1'b0;
            addr_q   <= '0;
            limit_q  <= '0;
            poll_cnt <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
            err_code <= ERR_NONE;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (frame_start) issued <= 1'b1;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    addr_q   <= req_addr;
                    limit_q  <= req_poll_limit;
                    poll_cnt <= '0;
                    err_code <= ERR_NONE;
                    state    <= ST_WREN;
                end
                ST_WREN: if (frame_done) begin
                    issued <= 1'b0;
                    state  <= ST_CHKWEL;
                end
                ST_CHKWEL: if (frame_done) begin
                    issued <= 1'b0;
                    if (!frame_rx[STAT_WEL]) begin
                        err      <= 1'b1;
                        err_code <= ERR_WEL_MISSING;
                        state    <= ST_IDLE;
                    end else begin
                        state <= ST_ERASE;
                    end
                end
                ST_ERASE: if (frame_done) begin
                    issued <= 1'b0;
                    state  <= ST_POLL;
                end
                ST_POLL: if (frame_done) begin
                    issued <= 1'b0;
                    if (!frame_rx[STAT_BUSY]) begin
                        state <= ST_IDLE;
                        if (frame_rx[STAT_WEL]) begin
                            err      <= 1'b1;
                            err_code <= ERR_WEL_STUCK;
                        end else begin
                            done <= 1'b1;
                        end
                    end else if (poll_next >= {1'b0, limit_q}) begin
                        err      <= 1'b1;
                        err_code <= ERR_TIMEOUT;
                        state    <= ST_IDLE;
                    end else begin
                        poll_cnt <= poll_next[POLL_W-1:0];
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/erase_sequencer.sv
// Top of the flash block-erase sequencer. It joins the sequence controller,
// the mode-0 frame engine and the chip-select gap timer.
// Assumes: a single flash device on the link; spi_miso changes only after
// falling serial-clock edges.
module erase_sequencer #(
    parameter int ADDR_W      = 24,
    parameter int POLL_W      = 16,
    parameter int MIN_CS_HIGH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [POLL_W-1:0] req_poll_limit,
    output logic              done,
    output logic              err,
    output logic [1:0]        err_code,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    localparam int FRAME_W = 8 + ADDR_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic               gap_idle;
    logic               frame_busy;
    logic               frame_done;
    logic [1:0]         frame_rx;
    logic               frame_start;
    logic [FRAME_W-1:0] frame_tx;
    logic [CNT_W-1:0]   frame_nbits;
    fe_pkg::err_code_t  code_w;

    fe_seq_ctrl #(
        .ADDR_W (ADDR_W),
        .POLL_W (POLL_W),
        .FRAME_W(FRAME_W),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_poll_limit(req_poll_limit),
        .gap_idle      (gap_idle),
        .frame_busy    (frame_busy),
        .frame_done    (frame_done),
        .frame_rx      (frame_rx),
        .frame_start   (frame_start),
        .frame_tx      (frame_tx),
        .frame_nbits   (frame_nbits),
        .done          (done),
        .err           (err),
        .err_code      (code_w)
    );

    fe_spi_frame #(
        .FRAME_W(FRAME_W),
        .CNT_W  (CNT_W)
    ) u_frame (
        .clk  (clk),
        .rst_n(rst_n),
        .start(frame_start),
        .tx   (frame_tx),
        .nbits(frame_nbits),
        .busy (frame_busy),
        .done (frame_done),
        .rx   (frame_rx),
        .cs_n (spi_cs_n),
        .sclk (spi_sclk),
        .mosi (spi_mosi),
        .miso (spi_miso)
    );

    fe_gap_timer #(
        .MIN_CS_HIGH(MIN_CS_HIGH)
    ) u_gap (
        .clk  (clk),
        .rst_n(rst_n),
        .load (frame_done),
        .idle (gap_idle)
    );

    // Present the error code as a plain vector at the boundary.
    always_comb err_code = code_w;

endmodule

// File: rtl/erase_sequencer_chk.sv
// Protocol checker for erase_sequencer, attached by bind. It watches the
// handshake, the result pulses and the SPI pins. Serial-clock pulses per
// frame and chip-select high time are measured with local counters.
// Assumes: synchronous active-low reset, as in the design.
module erase_sequencer_chk #(
    parameter int ADDR_W      = 24,
    parameter int MIN_CS_HIGH = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       done,
    input logic       err,
    input logic [1:0] err_code,
    input logic       spi_cs_n,
    input logic       spi_sclk,
    input logic       spi_mosi
);

    localparam int FRAME_W = 8 + ADDR_W;
    localparam int PW      = $clog2(FRAME_W + 2);
    localparam int HW      = $clog2(MIN_CS_HIGH + 2);

    logic [PW-1:0] pulses;
    logic          sclk_q;
    logic [HW-1:0] hi_cnt;

    // Count rising serial-clock edges inside the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulses <= '0;
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= spi_sclk;
            if (spi_cs_n)                  pulses <= '0;
            else if (spi_sclk && !sclk_q)  pulses <= pulses + 1'b1;
        end
    end

    // Count chip-select high cycles, saturating at the minimum.
    always_ff @(posedge clk) begin
        if (!rst_n)                          hi_cnt <= HW'(MIN_CS_HIGH);
        else if (!spi_cs_n)                  hi_cnt <= '0;
        else if (hi_cnt < HW'(MIN_CS_HIGH))  hi_cnt <= hi_cnt + 1'b1;
    end

    p_ready_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_frame_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> (pulses == PW'(8) || pulses == PW'(16) || pulses == PW'(FRAME_W)));

    p_err_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_code != 2'd0));

    p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (hi_cnt >= HW'(MIN_CS_HIGH)));

    p_sclk_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    p_mosi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> $stable(spi_mosi));

    p_result_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

endmodule

bind erase_sequencer erase_sequencer_chk #(
    .ADDR_W     (ADDR_W),
    .MIN_CS_HIGH(MIN_CS_HIGH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .done     (done),
    .err      (err),
    .err_code (err_code),
    .spi_cs_n (spi_cs_n),
    .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi)
);

// File: tb/erase_sequencer_tb.sv
// Scoreboard bench. The driver task queues the expected frames and the
// expected result of each request. A behavioural flash model pops and checks
// the frames, and a result monitor pops and checks the done/err pulses.
module erase_sequencer_tb;

    localparam int MIN_CS = 4;

    typedef struct {
        logic [7:0]  op;
        int          nbits;
        logic [23:0] addr;
    } frame_t;

    typedef struct {
        logic       ok;
        logic [1:0] code;
    } result_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic [15:0] req_poll_limit = '0;
    logic        done, err;
    logic [1:0]  err_code;
    logic        spi_cs_n, spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;

    int compared = 0;
    int mismatched = 0;

    frame_t  frame_q[$];
    result_t res_q[$];

    // flash model state and settings
    bit          cfg_wel_accept, cfg_wel_clear;
    int          cfg_busy_polls;
    bit          m_wel;
    int          m_busy_left;
    bit          frame_open = 1'b0;
    int          nb;
    logic [31:0] mo_sh;
    logic [7:0]  stat_sh;
    int          hi_cnt = 1000;
    bit          first_frame = 1'b1;

    always #2 clk = ~clk;

    erase_sequencer u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_poll_limit(req_poll_limit),
        .done          (done),
        .err           (err),
        .err_code      (err_code),
        .spi_cs_n      (spi_cs_n),
        .spi_sclk      (spi_sclk),
        .spi_mosi      (spi_mosi),
        .spi_miso      (spi_miso)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // chip-select high time, sampled away from the clock edge (R8)
    always @(negedge clk) begin
        if (spi_cs_n === 1'b1) hi_cnt++;
        else                   hi_cnt = 0;
    end

    // flash model: frame start
    always @(negedge spi_cs_n) begin
        if (rst_n) begin
            frame_open = 1'b1;
            nb = 0;
            mo_sh = '0;
            stat_sh = {6'b0, m_wel, (m_busy_left > 0)};
            if (!first_frame) chk("R8 cs high cycles >= min", (hi_cnt >= MIN_CS), 1);
            first_frame = 1'b0;
        end
    end

    // flash model: sample MOSI on rising serial clock
    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            mo_sh = {mo_sh[30:0], spi_mosi};
            nb++;
        end
    end

    // flash model: drive status on falling serial clock after the opcode
    always @(negedge spi_sclk) begin
        if (!spi_cs_n && nb >= 8) begin
            spi_miso = stat_sh[7];
            stat_sh = stat_sh << 1;
        end
    end

    // flash model: frame end, scoreboard compare and state update
    always @(posedge spi_cs_n) begin
        if (rst_n && frame_open) begin
            logic [7:0] op;
            frame_t e;
            frame_open = 1'b0;
            op = (nb >= 8) ? 8'(mo_sh >> (nb - 8)) : 8'h00;
            if (frame_q.size() == 0) begin
                chk("R2 unexpected extra frame", {24'h0, op}, 32'hFFFF_FFFF);
            end else begin
                e = frame_q.pop_front();
                if (e.op == 8'h06) begin
                    chk("R2 wren bits", nb, e.nbits);
                    chk("R2 wren opcode", op, e.op);
                end else if (e.op == 8'hD8) begin
                    chk("R4 erase clock count", nb, e.nbits);
                    chk("R4 erase opcode", op, e.op);
                    chk("R4 erase address", mo_sh[23:0], e.addr);
                end else begin
                    chk("R3 R5 status read bits", nb, e.nbits);
                    chk("R3 R5 status opcode", op, e.op);
                end
            end
            if (op == 8'h06 && nb == 8) m_wel = cfg_wel_accept;
            if (op == 8'hD8 && nb == 32) begin
                m_busy_left = cfg_busy_polls;
                if (cfg_busy_polls == 0 && cfg_wel_clear) m_wel = 1'b0;
            end
            if (op == 8'h05 && nb == 16 && m_busy_left > 0) begin
                m_busy_left--;
                if (m_busy_left == 0 && cfg_wel_clear) m_wel = 1'b0;
            end
            spi_miso = 1'b0;
        end
    end

    // result monitor (R5 R6 R7 R10)
    always @(negedge clk) begin
        if (rst_n && (done === 1'b1 || err === 1'b1)) begin
            if (res_q.size() == 0) begin
                chk("R10 unexpected result pulse", {done, err}, 2'b00);
            end else begin
                result_t r;
                r = res_q.pop_front();
                chk("R10 done/err pair", {done, err}, {r.ok, !r.ok});
                if (!r.ok) chk("R3 R6 R7 err_code", err_code, r.code);
            end
        end
    end

    task automatic exp_frame(input logic [7:0] op, input int nbits, input logic [23:0] addr);
        frame_t f;
        f.op = op; f.nbits = nbits; f.addr = addr;
        frame_q.push_back(f);
    endtask

    // driver: set up the flash model, queue expectations, issue the request
    task automatic run_req(input logic [23:0] addr, input logic [15:0] limit,
                           input bit wel_ok, input bit wel_clr, input int busy,
                           input int polls, input bit ok, input logic [1:0] code);
        result_t r;
        cfg_wel_accept = wel_ok;
        cfg_wel_clear  = wel_clr;
        cfg_busy_polls = busy;
        m_wel = 1'b0;
        m_busy_left = 0;
        exp_frame(8'h06, 8, 24'h0);
        exp_frame(8'h05, 16, 24'h0);
        if (wel_ok) begin
            exp_frame(8'hD8, 32, addr);
            for (int i = 0; i < polls; i++) exp_frame(8'h05, 16, 24'h0);
        end
        r.ok = ok; r.code = code;
        res_q.push_back(r);
        @(negedge clk);
        while (req_ready !== 1'b1) @(negedge clk);
        req_valid = 1'b1;
        req_addr = addr;
        req_poll_limit = limit;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 ready low after accept", req_ready, 1'b0);
        while (res_q.size() != 0) @(negedge clk);
        chk("R1 ready back after result", req_ready, 1'b1);
        chk("R3 R5 all expected frames seen", frame_q.size(), 0);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11 cs_n reset", spi_cs_n, 1'b1);
        chk("R11 sclk reset", spi_sclk, 1'b0);
        chk("R11 ready reset", req_ready, 1'b1);
        chk("R11 done/err reset", {done, err}, 2'b00);

        // R5: normal erase, three busy polls
        run_req(24'h3A0000, 16'd20, 1, 1, 3, 4, 1'b1, 2'd0);
        // R3: latch never set, no erase frame
        run_req(24'h120000, 16'd20, 0, 1, 0, 0, 1'b0, 2'd1);
        // R6: latch stuck after completion, all-ones address
        run_req(24'hFFFFFF, 16'd20, 1, 0, 1, 2, 1'b0, 2'd2);
        // R7: busy longer than the limit
        run_req(24'h050000, 16'd4, 1, 1, 10, 4, 1'b0, 2'd3);
        // R7 boundary: busy for limit-1 polls still finishes
        run_req(24'h0A0000, 16'd4, 1, 1, 3, 4, 1'b1, 2'd0);
        // R7 boundary: exactly limit busy polls times out
        run_req(24'h0B0000, 16'd4, 1, 1, 4, 4, 1'b0, 2'd3);
        // R4: zero address, no busy time
        run_req(24'h000000, 16'd1, 1, 1, 0, 1, 1'b1, 2'd0);
        // R7: limit of one with busy flash
        run_req(24'hA55AC3, 16'd1, 1, 1, 2, 1, 1'b0, 2'd3);

        repeat (10) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog expired R1 actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule